// File: doc/BRIEF.md
# Banked GPIO Register Controller

This block is a memory-mapped general-purpose I/O controller for a pin count that is a multiple of 32. Software reaches it through a simple 32-bit register bus and uses it to read the pin levels and to choose each pin's direction. It drives each output latch high or low with write-one-to-act registers, so no read-modify-write is needed. Each pin also has a two-bit field that hands the pin to an alternate function.

The register file is feature-major. Each feature has a run of consecutive 32-bit words, one word per 32 pins. The alternate-function feature is the exception: it packs 16 pins per word, so its run is twice as long. The rising-enable, falling-enable and edge-status groups belong to the same map, but this block does not hold them. It decodes accesses to those groups and forwards them to a neighbouring edge-detect unit, then returns that unit's read data on the bus.

The pins are sampled through a two-flop synchroniser before software can see them. The block drives an output vector, an output-enable vector and a packed vector of alternate-function selects toward the pad ring.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset every pin is an input (`pin_oe_o` all 0), every output latch is 0, every alternate-function field is 0 and `bus_rdata_o` is 0.
- R2: With W = NUM_PINS/32, the word at byte address 4·(f·W + k) holds word k of feature f, where f is 0 level, 1 direction, 2 set, 3 clear, 4 rising-enable, 5 falling-enable, 6 edge-status. Bit b of word k belongs to pin 32k+b. Address bits [1:0] are ignored.
- R3: A read of a level word returns the pin inputs as they were three clock edges before the read data appears: two synchroniser flops plus the read register. Writes to level words change nothing.
- R4: A direction word reads back what was last written. A 1 bit drives the matching `pin_oe_o` bit high (output) and a 0 bit makes the pin an input.
- R5: Writing a set word drives high the output latch of every pin whose data bit is 1 and leaves the other latches unchanged. Set words read as 0.
- R6: Writing a clear word drives low the output latch of every pin whose data bit is 1 and leaves the other latches unchanged. Clear words read as 0.
- R7: The alternate-function words start at word index 7·W and there are 2·W of them. Pin p sits in word 7·W + p/16 at bits [2·(p%16)+1 : 2·(p%16)] and drives `alt_sel_o[2p+1:2p]`. The words read back as written, and a field of 0 means plain GPIO.
- R8: An access to features 4, 5 or 6 asserts `edge_req_o` in the same cycle. It also presents `edge_sel_o` (0 rising, 1 falling, 2 status), `edge_word_o` = k, `edge_we_o` and `edge_wdata_o`. A read returns the value of `edge_rdata_i` from that cycle.
- R9: An access at word index 9·W or above reads 0, changes no pin output, enable or select, and raises no `edge_req_o`.
- R10: Read data appears on `bus_rdata_o` in the cycle after the read is accepted. In every cycle that follows a non-read cycle, `bus_rdata_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_valid_i | input | 1 | Bus access strobe, one access per cycle |
| bus_write_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| pin_in_i | input | NUM_PINS | Asynchronous pin inputs |
| pin_out_o | output | NUM_PINS | Output latches |
| pin_oe_o | output | NUM_PINS | Output enables (1 = drive) |
| alt_sel_o | output | 2*NUM_PINS | Alternate-function select, two bits per pin |
| edge_req_o | output | 1 | Access strobe toward the edge-detect unit |
| edge_we_o | output | 1 | Forwarded write flag |
| edge_sel_o | output | 2 | Edge register group: 0 rising, 1 falling, 2 status |
| edge_word_o | output | 8 | Word index inside the edge group |
| edge_wdata_o | output | 32 | Forwarded write data |
| edge_rdata_i | input | 32 | Read data from the edge-detect unit |

## Verification
The bench builds the controller with NUM_PINS = 96, so each feature has three words. The word-to-feature split then needs a true division by three, not a shift. This puts an odd word count in front of the decoder and moves the alternate-function run to a start (word 21) that is not a power of two. The top pin, 95, lands in the highest field of the sixth alternate-function word. The first unmapped word, 27, sits directly above the last mapped one, so the boundary between decoded and ignored addresses is tested exactly.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    // Feature groups in address order; the order sets the address map.
    typedef enum logic [2:0] {
        FEAT_LEVEL = 3'd0,
        FEAT_DIR   = 3'd1,
        FEAT_SET   = 3'd2,
        FEAT_CLR   = 3'd3,
        FEAT_RISE  = 3'd4,
        FEAT_FALL  = 3'd5,
        FEAT_STAT  = 3'd6,
        FEAT_ALT   = 3'd7
    } feat_e;

    // Decoded bus address.
    typedef struct packed {
        logic       hit;
        feat_e      feat;
        logic [7:0] word;
    } decode_t;

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 64,
    parameter int ADDR_W   = 12
) (
    input  logic [ADDR_W-1:0] addr_i,
    output decode_t           dec_o
);
    localparam int unsigned WPF       = NUM_PINS / 32;
    localparam int unsigned ALT_START = 7 * WPF;
    localparam int unsigned TOTAL     = 9 * WPF;

    logic [ADDR_W-3:0] widx;
    int unsigned       wi;

    assign widx = addr_i[ADDR_W-1:2];

    always_comb begin
        wi    = 32'(widx);
        dec_o = '0;
        if (wi < TOTAL) begin
            dec_o.hit = 1'b1;
            if (wi >= ALT_START) begin
                dec_o.feat = FEAT_ALT;
                dec_o.word = 8'(wi - ALT_START);
            end else begin
                dec_o.feat = feat_e'(3'(wi / WPF));
                dec_o.word = 8'(wi % WPF);
            end
        end
    end

endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH = 64
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    typedef struct packed {
        logic [WIDTH-1:0] s1;
        logic [WIDTH-1:0] s2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d.s1 = d_i;
        sync_d.s2 = sync_q.s1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= sync_d;
    end

    assign q_o = sync_q.s2;

endmodule

// File: rtl/gpio_edge_fwd.sv
module gpio_edge_fwd
    import gpio_bank_pkg::*;
(
    input  logic       valid_i,
    input  logic       write_i,
    input  decode_t    dec_i,
    output logic       req_o,
    output logic       we_o,
    output logic [1:0] sel_o,
    output logic [7:0] word_o
);
    always_comb begin
        req_o  = 1'b0;
        sel_o  = 2'd0;
        word_o = dec_i.word;
        we_o   = write_i;
        if (valid_i && dec_i.hit) begin
            unique case (dec_i.feat)
                FEAT_RISE: begin req_o = 1'b1; sel_o = 2'd0; end
                FEAT_FALL: begin req_o = 1'b1; sel_o = 2'd1; end
                FEAT_STAT: begin req_o = 1'b1; sel_o = 2'd2; end
                default:   ;
            endcase
        end
    end

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 64,
    parameter int ADDR_W   = 12
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  bus_valid_i,
    input  logic                  bus_write_i,
    input  logic [ADDR_W-1:0]     bus_addr_i,
    input  logic [31:0]           bus_wdata_i,
    output logic [31:0]           bus_rdata_o,
    input  logic [NUM_PINS-1:0]   pin_in_i,
    output logic [NUM_PINS-1:0]   pin_out_o,
    output logic [NUM_PINS-1:0]   pin_oe_o,
    output logic [2*NUM_PINS-1:0] alt_sel_o,
    output logic                  edge_req_o,
    output logic                  edge_we_o,
    output logic [1:0]            edge_sel_o,
    output logic [7:0]            edge_word_o,
    output logic [31:0]           edge_wdata_o,
    input  logic [31:0]           edge_rdata_i
);
    localparam int WPF     = NUM_PINS / 32;
    localparam int ALT_WDS = 2 * WPF;

    typedef struct packed {
        logic [NUM_PINS-1:0]   dir;
        logic [NUM_PINS-1:0]   out;
        logic [2*NUM_PINS-1:0] alt;
        logic [31:0]           rdata;
    } state_t;

    state_t              st_d, st_q;
    decode_t             dec;
    logic [NUM_PINS-1:0] level;
    logic                wr_hit, rd_hit;

    gpio_addr_decode #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) i_dec (
        .addr_i (bus_addr_i),
        .dec_o  (dec)
    );

    gpio_sync #(.WIDTH(NUM_PINS)) i_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (pin_in_i),
        .q_o    (level)
    );

    gpio_edge_fwd i_edge (
        .valid_i (bus_valid_i),
        .write_i (bus_write_i),
        .dec_i   (dec),
        .req_o   (edge_req_o),
        .we_o    (edge_we_o),
        .sel_o   (edge_sel_o),
        .word_o  (edge_word_o)
    );

    assign edge_wdata_o = bus_wdata_i;
    assign wr_hit = bus_valid_i &  bus_write_i & dec.hit;
    assign rd_hit = bus_valid_i & ~bus_write_i & dec.hit;

    always_comb begin
        st_d       = st_q;
        st_d.rdata = '0;

        if (wr_hit) begin
            unique case (dec.feat)
                FEAT_DIR: begin
                    for (int k = 0; k < WPF; k++)
                        if (dec.word == 8'(k)) st_d.dir[k*32 +: 32] = bus_wdata_i;
                end
                FEAT_SET: begin
                    for (int k = 0; k < WPF; k++)
                        if (dec.word == 8'(k))
                            st_d.out[k*32 +: 32] = st_q.out[k*32 +: 32] | bus_wdata_i;
                end
                FEAT_CLR: begin
                    for (int k = 0; k < WPF; k++)
                        if (dec.word == 8'(k))
                            st_d.out[k*32 +: 32] = st_q.out[k*32 +: 32] & ~bus_wdata_i;
                end
                FEAT_ALT: begin
                    for (int k = 0; k < ALT_WDS; k++)
                        if (dec.word == 8'(k)) st_d.alt[k*32 +: 32] = bus_wdata_i;
                end
                default: ;
            endcase
        end

        if (rd_hit) begin
            unique case (dec.feat)
                FEAT_LEVEL: begin
                    for (int k = 0; k < WPF; k++)
                        if (dec.word == 8'(k)) st_d.rdata = level[k*32 +: 32];
                end
                FEAT_DIR: begin
                    for (int k = 0; k < WPF; k++)
                        if (dec.word == 8'(k)) st_d.rdata = st_q.dir[k*32 +: 32];
                end
                FEAT_ALT: begin
                    for (int k = 0; k < ALT_WDS; k++)
                        if (dec.word == 8'(k)) st_d.rdata = st_q.alt[k*32 +: 32];
                end
                FEAT_RISE, FEAT_FALL, FEAT_STAT: st_d.rdata = edge_rdata_i;
                default: st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign bus_rdata_o = st_q.rdata;
    assign pin_out_o   = st_q.out;
    assign pin_oe_o    = st_q.dir;
    assign alt_sel_o   = st_q.alt;

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
    parameter int NUM_PINS = 64,
    parameter int ADDR_W   = 12
) (
    input logic                  clk_i,
    input logic                  rst_ni,
    input logic                  bus_valid_i,
    input logic                  bus_write_i,
    input logic [ADDR_W-1:0]     bus_addr_i,
    input logic [31:0]           bus_rdata_o,
    input logic [NUM_PINS-1:0]   pin_out_o,
    input logic [NUM_PINS-1:0]   pin_oe_o,
    input logic [2*NUM_PINS-1:0] alt_sel_o,
    input logic                  edge_req_o
);
    localparam int unsigned TOTAL = 9 * (NUM_PINS / 32);

    logic unmapped, is_wr;
    assign unmapped = bus_valid_i && (32'(bus_addr_i[ADDR_W-1:2]) >= TOTAL);
    assign is_wr    = bus_valid_i && bus_write_i;

    // R10
    idle_rdata_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(bus_valid_i && !bus_write_i) |=> (bus_rdata_o == 32'd0));

    // R9
    unmapped_no_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        unmapped |-> !edge_req_o);

    // R9
    unmapped_no_effect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        unmapped |=> ($stable(pin_out_o) && $stable(pin_oe_o) && $stable(alt_sel_o)));

    // R8
    edge_needs_access_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        edge_req_o |-> bus_valid_i);

    // R4
    oe_only_by_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !is_wr |=> $stable(pin_oe_o));

    // R5
    out_only_by_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !is_wr |=> $stable(pin_out_o));

    // R7
    alt_only_by_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !is_wr |=> $stable(alt_sel_o));

endmodule

bind gpio_bank_ctrl gpio_bank_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) i_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_valid_i (bus_valid_i),
    .bus_write_i (bus_write_i),
    .bus_addr_i  (bus_addr_i),
    .bus_rdata_o (bus_rdata_o),
    .pin_out_o   (pin_out_o),
    .pin_oe_o    (pin_oe_o),
    .alt_sel_o   (alt_sel_o),
    .edge_req_o  (edge_req_o)
);

// File: tb/test_gpio_bank_ctrl.sv
module test_gpio_bank_ctrl;
    localparam int NP  = 96;
    localparam int AW  = 12;
    localparam int WPF = NP / 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_valid = 1'b0, bus_write = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NP-1:0]   pin_in = '0, pin_out, pin_oe;
    logic [2*NP-1:0] alt_sel;
    logic            edge_req, edge_we;
    logic [1:0]      edge_sel;
    logic [7:0]      edge_word;
    logic [31:0]     edge_wdata, edge_rdata;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    // Stand-in edge-detect unit: read data encodes the group and word.
    assign edge_rdata = 32'hE000_0000 | (32'(edge_sel) << 8) | 32'(edge_word);

    gpio_bank_ctrl #(.NUM_PINS(NP), .ADDR_W(AW)) i_gpio_bank_ctrl (
        .clk_i(clk), .rst_ni(rst_n),
        .bus_valid_i(bus_valid), .bus_write_i(bus_write),
        .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .pin_in_i(pin_in), .pin_out_o(pin_out), .pin_oe_o(pin_oe), .alt_sel_o(alt_sel),
        .edge_req_o(edge_req), .edge_we_o(edge_we), .edge_sel_o(edge_sel),
        .edge_word_o(edge_word), .edge_wdata_o(edge_wdata), .edge_rdata_i(edge_rdata)
    );

    task automatic chk(input string tag, input logic [2*NP-1:0] act, input logic [2*NP-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural reference: register images, a pin history and the read value.
    logic [NP-1:0]   m_dir, m_out, m_h1, m_h2;
    logic [2*NP-1:0] m_alt;
    logic [31:0]     m_rd;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_dir = '0; m_out = '0; m_alt = '0; m_h1 = '0; m_h2 = '0; m_rd = '0;
        end else begin
            int wi, f, w;
            bit exp_req;
            m_rd = '0;
            wi = int'(bus_addr) / 4;
            exp_req = 1'b0;
            if (bus_valid && wi < 9 * WPF) begin
                if (wi >= 7 * WPF) begin f = 7; w = wi - 7 * WPF; end
                else begin f = wi / WPF; w = wi % WPF; end
                exp_req = (f >= 4 && f <= 6);
                if (bus_write) begin
                    if (f == 1) m_dir[w*32 +: 32] = bus_wdata;
                    if (f == 2) m_out[w*32 +: 32] = m_out[w*32 +: 32] | bus_wdata;
                    if (f == 3) m_out[w*32 +: 32] = m_out[w*32 +: 32] & ~bus_wdata;
                    if (f == 7) m_alt[w*32 +: 32] = bus_wdata;
                end else begin
                    if (f == 0) m_rd = m_h2[w*32 +: 32];
                    if (f == 1) m_rd = m_dir[w*32 +: 32];
                    if (f >= 4 && f <= 6) m_rd = 32'hE000_0000 | ((f - 4) << 8) | w;
                    if (f == 7) m_rd = m_alt[w*32 +: 32];
                end
            end
            if (bus_valid) chk("R8 edge_req", 192'(edge_req), 192'(exp_req));
            m_h2 = m_h1;
            m_h1 = pin_in;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R10 rdata", 192'(bus_rdata), 192'(m_rd));
            chk("R4 oe", 192'(pin_oe), 192'(m_dir));
            chk("R5 out", 192'(pin_out), 192'(m_out));
            chk("R7 alt", alt_sel, m_alt);
        end
    end

    // Tasks start just after a falling edge and end on the next one.
    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        chk(tag, 192'(bus_rdata), 192'(exp));
    endtask

    initial begin
        logic [NP-1:0] held_out;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 oe", 192'(pin_oe), 192'(0));
        chk("R1 out", 192'(pin_out), 192'(0));
        chk("R1 alt", alt_sel, '0);
        chk("R1 rdata", 192'(bus_rdata), 192'(0));
        rd(12'h010, 32'h0, "R1 dir word1");

        // R4 direction
        wr(12'h010, 32'hFFFF_0000);
        chk("R10 idle after write", 192'(bus_rdata), 192'(0));
        rd(12'h010, 32'hFFFF_0000, "R4 dir readback");
        chk("R4 oe word1", 192'(pin_oe[63:32]), 192'(32'hFFFF_0000));
        // R2 low address bits ignored, neighbour word untouched
        rd(12'h011, 32'hFFFF_0000, "R2 low bits");
        rd(12'h00C, 32'h0, "R2 dir word0");

        // R5 set, zero bits leave others alone
        wr(12'h01C, 32'h00F0_00F0);
        wr(12'h01C, 32'h0000_0F00);
        chk("R5 set merge", 192'(pin_out[63:32]), 192'(32'h00F0_0FF0));
        rd(12'h01C, 32'h0, "R5 set reads 0");

        // R6 clear
        wr(12'h028, 32'h0000_00F0);
        chk("R6 clear", 192'(pin_out[63:32]), 192'(32'h00F0_0F00));
        rd(12'h028, 32'h0, "R6 clear reads 0");

        // R3 level latency and read-only
        pin_in = {32'hA5A5_0001, 32'h1234_5678, 32'h0BAD_F00D};
        repeat (3) @(negedge clk);
        rd(12'h008, 32'hA5A5_0001, "R3 level word2");
        pin_in = {32'h5A5A_0002, 32'h1234_5678, 32'h0BAD_F00D};
        rd(12'h008, 32'hA5A5_0001, "R3 level old 0");
        rd(12'h008, 32'hA5A5_0001, "R3 level old 1");
        rd(12'h008, 32'h5A5A_0002, "R3 level new");
        wr(12'h008, 32'hFFFF_FFFF);
        rd(12'h008, 32'h5A5A_0002, "R3 level write ignored");

        // R7 alternate function (word 21 + p/16)
        wr(12'h060, 32'h0000_000C);
        chk("R7 pin49 field", 192'(alt_sel[99:98]), 192'(3));
        rd(12'h060, 32'h0000_000C, "R7 alt readback");
        wr(12'h068, 32'h4000_0000);
        chk("R7 pin95 field", 192'(alt_sel[191:190]), 192'(1));

        // R8 forwarding to edge unit (falling group, word 1)
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 12'h040; bus_wdata = 32'hCAFE_0001;
        #1;
        chk("R8 req", 192'(edge_req), 192'(1));
        chk("R8 sel", 192'(edge_sel), 192'(1));
        chk("R8 word", 192'(edge_word), 192'(1));
        chk("R8 we", 192'(edge_we), 192'(1));
        chk("R8 wdata", 192'(edge_wdata), 192'(32'hCAFE_0001));
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        rd(12'h050, 32'hE000_0202, "R8 status read");

        // R9 unmapped region
        held_out = pin_out;
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 12'h06C; bus_wdata = 32'hFFFF_FFFF;
        #1;
        chk("R9 no edge req", 192'(edge_req), 192'(0));
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        chk("R9 out unchanged", 192'(pin_out), 192'(held_out));
        rd(12'h06C, 32'h0, "R9 read first unmapped");
        rd(12'hFFC, 32'h0, "R9 read top");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule